// File: doc/BRIEF.md
# Block Memory Copy and Search Sequencer

This block walks a byte region of memory on its own, through a single memory port. It either copies bytes from a source region to a destination region, or scans a source region for a byte equal to a search key. Each operation is set by three mode bits: copy or compare, ascending or descending addresses, and a single step or a run that repeats until done. The host supplies the starting source pointer, destination pointer, byte count and key together with a one-cycle start pulse.

The engine holds its own copy of the two 16-bit pointers and the 16-bit count, and steps them as each byte is handled. The count is tested only after it has been decremented, so a start count of zero runs through all 65536 bytes. After each step the engine updates three flags. The equal flag and the negative flag come from the key minus the byte read. The count-remaining flag is set when the count is not zero. A repeated search stops at the first match or when the count runs out, whichever happens first. When the operation ends, a one-cycle done pulse is issued, and the final pointers, count and flags are held on the outputs.

Top module: `blkmove_engine`

## Requirements
- R1: Reset state. While reset is asserted and after it is released, busy, done, mem_req and all three flags are 0.
- R2: Copy step. Each copy step reads the byte at the source pointer and writes it to the destination pointer. It then moves both pointers by one, up when dir_dec=0 and down when dir_dec=1, and decrements the count by one.
- R3: Single copy flags. After a single copy (op_rep=0), flag_pv equals (count != 0). flag_z and flag_s keep their earlier values.
- R4: Repeated copy. With op_cmp=0 and op_rep=1, the copy repeats until the count reaches zero. The number of bytes written equals the start count, and at the end flag_pv is 0.
- R5: Zero start count. A repeated copy that starts with a count of 0 makes exactly 65536 writes and ends with the count at 0.
- R6: Compare step. Each compare step (op_cmp=1) reads the byte at the source pointer. It sets flag_z when the key equals the byte, and sets flag_s from bit 7 of (key minus byte). It then moves the source pointer by one and decrements the count.
- R7: Compare count flag. After any compare, flag_pv equals (count != 0).
- R8: Repeated compare termination. A repeated compare stops right after the first matching byte, with flag_z=1. If no byte matches, it stops when the count reaches 0, with flag_z=0 and flag_pv=0.
- R9: A compare never writes memory and leaves the destination pointer unchanged.
- R10: Pointers wrap modulo 65536 in both directions.
- R11: start is accepted only while idle and is ignored while busy. busy is 1 from the cycle after an accepted start until the operation ends. done is then 1 for exactly one cycle, with busy 0 and the final values on the outputs.
- R12: Memory port. mem_req stays high, with mem_addr, mem_we and mem_wdata held stable, until mem_ack is seen. mem_we=1 marks a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins an operation |
| op_cmp | input | 1 | 1 = compare/search, 0 = copy |
| dir_dec | input | 1 | 1 = pointers move down, 0 = up |
| op_rep | input | 1 | 1 = repeat until termination, 0 = single step |
| src_in | input | 16 | Starting source pointer |
| dst_in | input | 16 | Starting destination pointer |
| cnt_in | input | 16 | Starting byte count |
| key_in | input | 8 | Search key |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current byte count |
| flag_z | output | 1 | Key matched the last byte compared |
| flag_s | output | 1 | Key minus byte was negative |
| flag_pv | output | 1 | Count not zero after the last step |

## Verification
The bench starts a repeated copy with a count of zero and counts the writes. A design that tested the count before decrementing it would make no transfers, and one that stopped early would make fewer than 65536. Repeated searches are run once with the match partway through the region and once with no match at all. An engine that ignored the match would run on to a zero count, and one that confused the two stop conditions would report the wrong pair of flags. Descending runs that cross address zero show whether the pointers wrap. Memory with wait states, and a second start pulse sent mid-run, show whether the engine drops or repeats accesses and whether it lets a busy operation be reloaded.

// File: rtl/blk_pkg.sv
package blk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } blk_state_t;

  typedef struct packed {
    logic cmp;
    logic dec;
    logic rep;
  } blk_op_t;
endpackage

// File: rtl/blk_cmp.sv
module blk_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] key,
  input  logic [DATA_W-1:0] data,
  output logic              eq,
  output logic              neg
);
  logic [DATA_W-1:0] diff;

  always_comb begin
    diff = key - data;
    eq   = (diff == '0);
    neg  = diff[DATA_W-1];
  end
endmodule

// File: rtl/blk_seq.sv
module blk_seq
  import blk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  blk_op_t    op_in,
  input  logic       mem_ack,
  input  logic       more,
  output blk_state_t state_q,
  output blk_op_t    op_q,
  output logic       load,
  output logic       rd_fire,
  output logic       step_end
);
  blk_state_t state_d;
  blk_op_t    op_d;
  logic       op_en;

  always_comb begin
    load     = start && (state_q == ST_IDLE);
    rd_fire  = (state_q == ST_READ) && mem_ack;
    step_end = (rd_fire && op_q.cmp) || ((state_q == ST_WRITE) && mem_ack);
    op_en    = load;
    op_d     = op_in;
    state_d  = state_q;
    case (state_q)
      ST_IDLE:  if (load) state_d = ST_READ;
      ST_READ:  if (mem_ack) begin
                  if (!op_q.cmp)  state_d = ST_WRITE;
                  else if (more)  state_d = ST_READ;
                  else            state_d = ST_FIN;
                end
      ST_WRITE: if (mem_ack) state_d = more ? ST_READ : ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      if (op_en) op_q <= op_d;
    end
  end
endmodule

// File: rtl/blk_datapath.sv
module blk_datapath
  import blk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rd_fire,
  input  logic              step_end,
  input  blk_op_t           op_q,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [DATA_W-1:0] key_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [DATA_W-1:0] byte_q,
  output logic              z_q,
  output logic              s_q,
  output logic              pv_q,
  output logic              more
);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);

  logic [DATA_W-1:0] key_q, key_d, byte_d;
  logic [ADDR_W-1:0] src_d, dst_d, src_step, dst_step;
  logic [CNT_W-1:0]  cnt_d, cnt_step;
  logic              z_d, s_d, pv_d;
  logic              eq, neg;
  logic              ptr_en, dst_en, flag_en, key_en, byte_en;

  blk_cmp #(.DATA_W(DATA_W)) u_cmp (
    .key  (key_q),
    .data (rdata),
    .eq   (eq),
    .neg  (neg)
  );

  always_comb begin
    src_step = op_q.dec ? (src_q - ONE_A) : (src_q + ONE_A);
    dst_step = op_q.dec ? (dst_q - ONE_A) : (dst_q + ONE_A);
    cnt_step = cnt_q - ONE_C;
    more     = op_q.rep && (cnt_step != '0) && !(op_q.cmp && eq);

    ptr_en   = load || step_end;
    dst_en   = load || (step_end && !op_q.cmp);
    flag_en  = step_end;
    key_en   = load;
    byte_en  = rd_fire;

    src_d  = load ? src_in : src_step;
    dst_d  = load ? dst_in : dst_step;
    cnt_d  = load ? cnt_in : cnt_step;
    key_d  = key_in;
    byte_d = rdata;
    pv_d   = (cnt_step != '0);
    z_d    = op_q.cmp ? eq  : z_q;
    s_d    = op_q.cmp ? neg : s_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      key_q  <= '0;
      byte_q <= '0;
      z_q    <= 1'b0;
      s_q    <= 1'b0;
      pv_q   <= 1'b0;
    end else begin
      if (ptr_en)  src_q  <= src_d;
      if (ptr_en)  cnt_q  <= cnt_d;
      if (dst_en)  dst_q  <= dst_d;
      if (key_en)  key_q  <= key_d;
      if (byte_en) byte_q <= byte_d;
      if (flag_en) begin
        z_q  <= z_d;
        s_q  <= s_d;
        pv_q <= pv_d;
      end
    end
  end
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
  import blk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_cmp,
  input  logic              dir_dec,
  input  logic              op_rep,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [DATA_W-1:0] key_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] src_out,
  output logic [ADDR_W-1:0] dst_out,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_pv
);
  logic       rst_meta_n, rst_sync_n;
  blk_state_t state_q;
  blk_op_t    op_in, op_q;
  logic       load, rd_fire, step_end, more;
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign op_in = '{cmp: op_cmp, dec: dir_dec, rep: op_rep};

  blk_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .op_in    (op_in),
    .mem_ack  (mem_ack),
    .more     (more),
    .state_q  (state_q),
    .op_q     (op_q),
    .load     (load),
    .rd_fire  (rd_fire),
    .step_end (step_end)
  );

  blk_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .rd_fire  (rd_fire),
    .step_end (step_end),
    .op_q     (op_q),
    .src_in   (src_in),
    .dst_in   (dst_in),
    .cnt_in   (cnt_in),
    .key_in   (key_in),
    .rdata    (mem_rdata),
    .src_q    (src_out),
    .dst_q    (dst_out),
    .cnt_q    (cnt_out),
    .byte_q   (byte_q),
    .z_q      (flag_z),
    .s_q      (flag_s),
    .pv_q     (flag_pv),
    .more     (more)
  );

  always_comb begin
    mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
    mem_we    = (state_q == ST_WRITE);
    mem_addr  = (state_q == ST_WRITE) ? dst_out : src_out;
    mem_wdata = byte_q;
    busy      = mem_req;
    done      = (state_q == ST_FIN);
  end
endmodule

// File: rtl/blkmove_engine_chk.sv
module blkmove_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] dst_out,
  input logic [CNT_W-1:0]  cnt_out,
  input logic              flag_z,
  input logic              flag_pv,
  input logic              cmp_q,
  input logic              rep_q
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R9
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmp_q |-> !mem_we);

  // R9
  cmp_dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmp_q && $past(busy) |-> $stable(dst_out));

  // R7
  pv_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flag_pv == (cnt_out != '0));

  // R4
  rep_copy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && rep_q && !cmp_q |-> (cnt_out == '0) && !flag_pv);

  // R8
  rep_cmp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && rep_q && cmp_q |-> flag_z || !flag_pv);
endmodule

bind blkmove_engine blkmove_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .busy      (busy),
  .done      (done),
  .dst_out   (dst_out),
  .cnt_out   (cnt_out),
  .flag_z    (flag_z),
  .flag_pv   (flag_pv),
  .cmp_q     (op_q.cmp),
  .rep_q     (op_q.rep)
);

// File: tb/tb_blkmove_engine.sv
module tb_blkmove_engine;
  logic        clk, rst_n, start, op_cmp, dir_dec, op_rep;
  logic [15:0] src_in, dst_in, cnt_in, mem_addr, src_out, dst_out, cnt_out;
  logic [7:0]  key_in, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_ack, busy, done, flag_z, flag_s, flag_pv;

  logic [7:0]  mem [0:65535];
  logic [2:0]  wait_cnt;
  logic [2:0]  ack_delay;
  int          wr_count;
  int          total, bad;
  bit          hung;

  blkmove_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_cmp(op_cmp), .dir_dec(dir_dec),
    .op_rep(op_rep), .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .key_in(key_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
    .flag_z(flag_z), .flag_s(flag_s), .flag_pv(flag_pv)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign mem_ack   = mem_req && (wait_cnt == ack_delay);
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!mem_req || mem_ack) wait_cnt <= 3'd0;
    else                     wait_cnt <= wait_cnt + 3'd1;
    if (mem_req && mem_we && mem_ack) begin
      mem[mem_addr] <= mem_wdata;
      wr_count      <= wr_count + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  int wr_base;

  task automatic run_op(input logic c, input logic d, input logic r,
                        input logic [15:0] s, input logic [15:0] t,
                        input logic [15:0] n, input logic [7:0] k);
    int lim;
    @(negedge clk);
    op_cmp = c; dir_dec = d; op_rep = r;
    src_in = s; dst_in = t; cnt_in = n; key_in = k;
    wr_base = wr_count;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy after start", busy, 1'b1);
    lim = 0;
    while (!done && lim < 140000) begin
      @(negedge clk);
      lim++;
    end
    chk("R11 done reached", done, 1'b1);
    chk("R11 busy low at done", busy, 1'b0);
  endtask

  task automatic after_done;
    @(negedge clk);
    chk("R11 done one cycle", done, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 req", mem_req, 1'b0);
    chk("R1 flags", {flag_z, flag_s, flag_pv}, 3'b000);
  endtask

  task automatic t_copy_single_inc;
    mem[16'h0100] = 8'hA5; mem[16'h0200] = 8'h00;
    ack_delay = 3'd0;
    run_op(1'b0, 1'b0, 1'b0, 16'h0100, 16'h0200, 16'd3, 8'h00);
    chk("R2 data", mem[16'h0200], 8'hA5);
    chk("R2 src", src_out, 16'h0101);
    chk("R2 dst", dst_out, 16'h0201);
    chk("R2 cnt", cnt_out, 16'd2);
    chk("R3 pv set", flag_pv, 1'b1);
    chk("R2 one write", wr_count - wr_base, 1);
    after_done();
  endtask

  task automatic t_copy_single_dec;
    mem[16'h0150] = 8'h3C;
    run_op(1'b0, 1'b1, 1'b0, 16'h0150, 16'h0250, 16'd1, 8'h00);
    chk("R2 dec data", mem[16'h0250], 8'h3C);
    chk("R2 dec src", src_out, 16'h014F);
    chk("R2 dec dst", dst_out, 16'h024F);
    chk("R3 pv clear", flag_pv, 1'b0);
    after_done();
  endtask

  task automatic t_copy_repeat_inc;
    for (int i = 0; i < 5; i++) mem[16'h0300 + 16'(i)] = 8'(8'h40 + i);
    ack_delay = 3'd2;
    run_op(1'b0, 1'b0, 1'b1, 16'h0300, 16'h0380, 16'd5, 8'h00);
    for (int i = 0; i < 5; i++) chk("R4 data", mem[16'h0380 + 16'(i)], 8'(8'h40 + i));
    chk("R4 writes", wr_count - wr_base, 5);
    chk("R4 cnt", cnt_out, 16'd0);
    chk("R4 pv", flag_pv, 1'b0);
    chk("R4 src", src_out, 16'h0305);
    ack_delay = 3'd0;
    after_done();
  endtask

  task automatic t_copy_wrap_dec;
    mem[16'h0001] = 8'h11; mem[16'h0000] = 8'h22; mem[16'hFFFF] = 8'h33;
    run_op(1'b0, 1'b1, 1'b1, 16'h0001, 16'h0702, 16'd3, 8'h00);
    chk("R10 src wrap", src_out, 16'hFFFE);
    chk("R10 dst", dst_out, 16'h06FF);
    chk("R10 data last", mem[16'h0700], 8'h33);
    chk("R10 data first", mem[16'h0702], 8'h11);
    after_done();
  endtask

  task automatic t_cmp_single;
    mem[16'h0400] = 8'h20;
    run_op(1'b1, 1'b0, 1'b0, 16'h0400, 16'h1234, 16'd2, 8'h10);
    chk("R6 neg z", flag_z, 1'b0);
    chk("R6 neg s", flag_s, 1'b1);
    chk("R6 src", src_out, 16'h0401);
    chk("R7 pv", flag_pv, 1'b1);
    chk("R9 dst kept", dst_out, 16'h1234);
    after_done();
    mem[16'h0410] = 8'h10;
    run_op(1'b1, 1'b1, 1'b0, 16'h0410, 16'h1234, 16'd1, 8'h20);
    chk("R6 pos s", flag_s, 1'b0);
    chk("R6 dec src", src_out, 16'h040F);
    chk("R7 pv zero", flag_pv, 1'b0);
    after_done();
    mem[16'h0420] = 8'h77;
    run_op(1'b1, 1'b0, 1'b0, 16'h0420, 16'h1234, 16'd9, 8'h77);
    chk("R6 eq z", flag_z, 1'b1);
    chk("R6 eq s", flag_s, 1'b0);
    chk("R6 cnt", cnt_out, 16'd8);
    after_done();
  endtask

  task automatic t_cmp_repeat;
    for (int i = 0; i < 5; i++) mem[16'h0500 + 16'(i)] = 8'(i + 1);
    ack_delay = 3'd1;
    run_op(1'b1, 1'b0, 1'b1, 16'h0500, 16'h0900, 16'd5, 8'h03);
    chk("R8 match z", flag_z, 1'b1);
    chk("R8 match src", src_out, 16'h0503);
    chk("R8 match cnt", cnt_out, 16'd2);
    chk("R8 match pv", flag_pv, 1'b1);
    chk("R9 no write", wr_count - wr_base, 0);
    after_done();
    run_op(1'b1, 1'b0, 1'b1, 16'h0500, 16'h0900, 16'd4, 8'h99);
    chk("R8 exhaust z", flag_z, 1'b0);
    chk("R8 exhaust pv", flag_pv, 1'b0);
    chk("R8 exhaust src", src_out, 16'h0504);
    chk("R9 dst kept", dst_out, 16'h0900);
    chk("R9 no write", wr_count - wr_base, 0);
    ack_delay = 3'd0;
    after_done();
  endtask

  task automatic t_start_ignored;
    for (int i = 0; i < 4; i++) mem[16'h0600 + 16'(i)] = 8'(8'hC0 + i);
    ack_delay = 3'd3;
    @(negedge clk);
    op_cmp = 1'b0; dir_dec = 1'b0; op_rep = 1'b1;
    src_in = 16'h0600; dst_in = 16'h0680; cnt_in = 16'd4; key_in = 8'h00;
    wr_base = wr_count;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    src_in = 16'h0A00; dst_in = 16'h0B00; cnt_in = 16'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int lim = 0; lim < 200 && !done; lim++) @(negedge clk);
    chk("R11 ignored src", src_out, 16'h0604);
    chk("R11 ignored dst", dst_out, 16'h0684);
    chk("R11 ignored writes", wr_count - wr_base, 4);
    chk("R11 data", mem[16'h0683], 8'hC3);
    ack_delay = 3'd0;
    after_done();
  endtask

  task automatic t_copy_full;
    mem[16'h2000] = 8'h5A;
    run_op(1'b0, 1'b0, 1'b1, 16'h2000, 16'h2000, 16'd0, 8'h00);
    chk("R5 writes", wr_count - wr_base, 65536);
    chk("R5 cnt", cnt_out, 16'd0);
    chk("R5 src", src_out, 16'h2000);
    chk("R5 data", mem[16'h2000], 8'h5A);
    after_done();
  endtask

  initial begin
    hung = 1'b0;
    repeat (199000) @(posedge clk);
    hung = 1'b1;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; wr_count = 0; wait_cnt = 3'd0; ack_delay = 3'd0;
    start = 1'b0; op_cmp = 1'b0; dir_dec = 1'b0; op_rep = 1'b0;
    src_in = '0; dst_in = '0; cnt_in = '0; key_in = '0;
    for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 7);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_copy_single_inc();
    t_copy_single_dec();
    t_copy_repeat_inc();
    t_copy_wrap_dec();
    t_cmp_single();
    t_cmp_repeat();
    t_start_ignored();
    t_copy_full();
    if (!hung) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule